// File: doc/BRIEF.md
# Byte-Wide Parallel Port Master with Programmable Wait States

This block moves bytes between a host-side request interface and external parallel slave devices over an 8-bit data bus. The host issues one of three transaction kinds: address write, data write or data read. Each request carries a 4-bit endpoint tag and, for writes, a byte. For every accepted transaction the block runs a two-phase bus cycle. It drives two clock strobes, an output enable for reads and a chip select. During writes it drives the bus. During reads it releases the bus and captures the byte on the data input.

A small configuration register sets four things. It picks which of the two strobes fires for a transaction: split by address/data, by write/read, or by odd/even endpoint. It gates strobe 1 and chip select on or off. It sets a wait-state count and raises a weak pull-up flag for the data pads. Wait states are counted in ticks of a chosen source. The source is either an external bus-side clock enable or an internal divide-by-4 enable of the system clock. Half of the wait states follow each phase.

The sequencer has five states. `S_IDLE` waits for a request. `S_LEAD` is the first phase, with the selected strobe high. `S_LEAD_WAIT` holds the first half of the wait states. `S_TRAIL` is the second phase, with the strobe low. `S_TRAIL_WAIT` holds the second half of the wait states.

The transitions are as follows:
- IDLE→LEAD on an accepted request.
- LEAD→LEAD_WAIT on a tick when the half count is nonzero, or LEAD→TRAIL on a tick when it is zero.
- LEAD_WAIT→TRAIL on the tick that uses up the count.
- TRAIL→TRAIL_WAIT on a tick when the half count is nonzero, or TRAIL→IDLE on a tick when it is zero.
- TRAIL_WAIT→IDLE on the tick that uses up the count.

Top module: `par_port_master`

## Requirements
- R1: After reset, all configuration fields are zero. busy, rd_valid, both strobes, pp_rd_en, pp_data_oe, pp_sel, pp_sel_drv, pp_strobe1_drv and pp_pull_en are all low.
- R2: A cfg_wr pulse while idle loads the configuration fields, seen on pp_pull_en in the next cycle. A cfg_wr pulse while busy is ignored.
- R3: With cfg_wait = W and tick period P, busy is high for exactly (2+2W)*P cycles. busy rises in the cycle after the accepting edge. P=1 when src_sel=0 with bus_tick held high. P=4 when src_sel=1, and that divider restarts at acceptance. The selected strobe is high for the first (1+W)*P of those cycles and low for the rest.
- R4: cfg_mode=00: strobe 1 serves address writes (req_kind=0), and strobe 2 serves data writes (req_kind=1) and data reads (req_kind=2).
- R5: cfg_mode=01: strobe 1 serves both write kinds and strobe 2 serves reads.
- R6: cfg_mode=1x: strobe 1 serves endpoints with bit 0 set (odd) and strobe 2 serves even endpoints, whatever the kind.
- R7: When cfg_str1_en is 0, pp_strobe1 and pp_strobe1_drv stay low. When cfg_sel_en is 0, pp_sel and pp_sel_drv stay low. Each drive flag equals its enable bit otherwise.
- R8: When chip select is enabled, pp_sel is high in every busy cycle and low when idle.
- R9: A read keeps pp_rd_en high and pp_data_oe low for the whole busy period. A write keeps pp_data_oe high with pp_data_o equal to the request byte, and keeps pp_rd_en low.
- R10: A read ends with a one-cycle rd_valid pulse in the first cycle after busy falls. rd_data then holds pp_data_i as it was in the last busy cycle.
- R11: Requests made while busy, and requests with req_kind=3, are ignored. They start no transaction and do not change the one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_mode | input | 2 | Strobe routing scheme |
| cfg_wait | input | 4 | Half of the total wait-state count |
| cfg_str1_en | input | 1 | Strobe 1 output enable |
| cfg_sel_en | input | 1 | Chip select output enable |
| cfg_pull_en | input | 1 | Pad pull-up request |
| src_sel | input | 1 | Tick source: 0 bus_tick, 1 clock/4 |
| bus_tick | input | 1 | Bus-side clock enable |
| req_valid | input | 1 | Transaction request |
| req_kind | input | 2 | 0 address write, 1 data write, 2 read, 3 none |
| req_ep | input | 4 | Endpoint tag |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Captured read byte |
| pp_data_o | output | 8 | Bus output byte |
| pp_data_oe | output | 1 | Bus output drive enable |
| pp_data_i | input | 8 | Bus input byte |
| pp_strobe1 | output | 1 | Clock strobe 1 |
| pp_strobe1_drv | output | 1 | Strobe 1 pin owned by port |
| pp_strobe2 | output | 1 | Clock strobe 2 |
| pp_rd_en | output | 1 | Output enable toward slave (read) |
| pp_sel | output | 1 | Chip select |
| pp_sel_drv | output | 1 | Chip select pin owned by port |
| pp_pull_en | output | 1 | Data pad pull-up flag |

## Verification
A sequencer stuck in the wrong state, or a wait counter off by one, shows up as a busy window or strobe-high window whose length is not the value the formula gives. The bench measures both windows on every transaction, so such a fault is caught within that transaction. A wrong routing decision drives the other strobe from the lead phase onward. A bad read capture shows as a wrong or missing rd_valid in the cycle right after busy falls. The sweeps cover every mode, kind, endpoint and several wait counts.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    typedef enum logic [1:0] {
        K_ADDR_WR = 2'd0,
        K_DATA_WR = 2'd1,
        K_DATA_RD = 2'd2,
        K_NONE    = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_LEAD       = 3'd1,
        S_LEAD_WAIT  = 3'd2,
        S_TRAIL      = 3'd3,
        S_TRAIL_WAIT = 3'd4
    } seq_e;

endpackage

// File: rtl/ppm_tick_gen.sv
module ppm_tick_gen #(
    parameter int DIV_RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic src_sel,
    input  logic bus_tick,
    output logic tick
);
    generate
        if (DIV_RATIO > 1) begin : g_div
            localparam int CW = $clog2(DIV_RATIO);
            localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (restart || cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end

            assign tick = src_sel ? (cnt == LAST) : bus_tick;
        end else begin : g_nodiv
            logic unused_nodiv;
            assign unused_nodiv = clk ^ rst_n ^ restart;
            assign tick = src_sel ? 1'b1 : bus_tick;
        end
    endgenerate
endmodule

// File: rtl/ppm_seq.sv
module ppm_seq
    import ppm_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [WAIT_W-1:0] half_wait,
    output logic              busy,
    output logic              lead,
    output logic              done
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    seq_e              state, state_nxt;
    logic [WAIT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        done      = 1'b0;
        busy      = 1'b1;
        lead      = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    state_nxt = S_LEAD;
                end
            end
            S_LEAD: begin
                lead = 1'b1;
                if (tick) begin
                    if (half_wait != '0) begin
                        state_nxt = S_LEAD_WAIT;
                        cnt_nxt   = half_wait;
                    end else begin
                        state_nxt = S_TRAIL;
                    end
                end
            end
            S_LEAD_WAIT: begin
                lead = 1'b1;
                if (tick) begin
                    if (cnt == ONE) begin
                        state_nxt = S_TRAIL;
                    end else begin
                        cnt_nxt = cnt - ONE;
                    end
                end
            end
            S_TRAIL: begin
                if (tick) begin
                    if (half_wait != '0) begin
                        state_nxt = S_TRAIL_WAIT;
                        cnt_nxt   = half_wait;
                    end else begin
                        state_nxt = S_IDLE;
                        done      = 1'b1;
                    end
                end
            end
            S_TRAIL_WAIT: begin
                if (tick) begin
                    if (cnt == ONE) begin
                        state_nxt = S_IDLE;
                        done      = 1'b1;
                    end else begin
                        cnt_nxt = cnt - ONE;
                    end
                end
            end
            default: begin
                state_nxt = S_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/ppm_strobe_route.sv
module ppm_strobe_route
    import ppm_pkg::*;
(
    input  logic [1:0] mode,
    input  kind_e      kind,
    input  logic       ep_odd,
    input  logic       busy,
    input  logic       lead,
    input  logic       str1_en,
    input  logic       sel_en,
    output logic       strobe1,
    output logic       strobe1_drv,
    output logic       strobe2,
    output logic       sel,
    output logic       sel_drv
);
    logic use_first;

    always_comb begin
        if (mode[1]) begin
            use_first = ep_odd;
        end else if (mode[0]) begin
            use_first = (kind != K_DATA_RD);
        end else begin
            use_first = (kind == K_ADDR_WR);
        end
    end

    assign strobe1     = lead && use_first && str1_en;
    assign strobe2     = lead && !use_first;
    assign strobe1_drv = str1_en;
    assign sel         = busy && sel_en;
    assign sel_drv     = sel_en;
endmodule

// File: rtl/par_port_master.sv
module par_port_master
    import ppm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EP_W      = 4,
    parameter int WAIT_W    = 4,
    parameter int DIV_RATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_str1_en,
    input  logic              cfg_sel_en,
    input  logic              cfg_pull_en,
    input  logic              src_sel,
    input  logic              bus_tick,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [EP_W-1:0]   req_ep,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] pp_data_o,
    output logic              pp_data_oe,
    input  logic [DATA_W-1:0] pp_data_i,
    output logic              pp_strobe1,
    output logic              pp_strobe1_drv,
    output logic              pp_strobe2,
    output logic              pp_rd_en,
    output logic              pp_sel,
    output logic              pp_sel_drv,
    output logic              pp_pull_en
);
    logic [1:0]        mode_q;
    logic [WAIT_W-1:0] wait_q;
    logic              str1_en_q;
    logic              sel_en_q;
    logic              pull_q;

    kind_e             kind_q;
    logic              ep_odd_q;
    logic [DATA_W-1:0] byte_q;

    logic accept;
    logic tick;
    logic lead;
    logic done;
    logic is_read;
    logic unused_ep_hi;

    assign unused_ep_hi = ^req_ep[EP_W-1:1];
    assign accept  = req_valid && !busy && (kind_e'(req_kind) != K_NONE);
    assign is_read = (kind_q == K_DATA_RD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            wait_q    <= '0;
            str1_en_q <= 1'b0;
            sel_en_q  <= 1'b0;
            pull_q    <= 1'b0;
        end else if (cfg_wr && !busy) begin
            mode_q    <= cfg_mode;
            wait_q    <= cfg_wait;
            str1_en_q <= cfg_str1_en;
            sel_en_q  <= cfg_sel_en;
            pull_q    <= cfg_pull_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_ADDR_WR;
            ep_odd_q <= 1'b0;
            byte_q   <= '0;
        end else if (accept) begin
            kind_q   <= kind_e'(req_kind);
            ep_odd_q <= req_ep[0];
            byte_q   <= req_wdata;
        end
    end

    ppm_tick_gen #(
        .DIV_RATIO (DIV_RATIO)
    ) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .src_sel  (src_sel),
        .bus_tick (bus_tick),
        .tick     (tick)
    );

    ppm_seq #(
        .WAIT_W (WAIT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .tick      (tick),
        .half_wait (wait_q),
        .busy      (busy),
        .lead      (lead),
        .done      (done)
    );

    ppm_strobe_route route_i (
        .mode        (mode_q),
        .kind        (kind_q),
        .ep_odd      (ep_odd_q),
        .busy        (busy),
        .lead        (lead),
        .str1_en     (str1_en_q),
        .sel_en      (sel_en_q),
        .strobe1     (pp_strobe1),
        .strobe1_drv (pp_strobe1_drv),
        .strobe2     (pp_strobe2),
        .sel         (pp_sel),
        .sel_drv     (pp_sel_drv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= done && is_read;
            if (done && is_read) begin
                rd_data <= pp_data_i;
            end
        end
    end

    assign pp_data_o  = byte_q;
    assign pp_data_oe = busy && !is_read;
    assign pp_rd_en   = busy && is_read;
    assign pp_pull_en = pull_q;
endmodule

module par_port_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rd_valid,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       pp_strobe1,
    input logic       pp_strobe1_drv,
    input logic       pp_strobe2,
    input logic       pp_sel,
    input logic       pp_sel_drv,
    input logic       pp_data_oe,
    input logic       pp_rd_en
);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && $past(busy)));

    a_r11_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_valid) && $past(req_kind) != 2'd3));

    a_r7_strobe1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_strobe1_drv |-> !pp_strobe1);

    a_r7_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_sel_drv |-> !pp_sel);

    a_r8_sel_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_sel_drv && busy) |-> pp_sel);

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(pp_data_oe && pp_rd_en));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pp_strobe1, pp_strobe2}));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pp_strobe1 && !pp_strobe2 && !pp_data_oe && !pp_rd_en && !pp_sel));
endmodule

bind par_port_master par_port_master_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .rd_valid       (rd_valid),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .pp_strobe1     (pp_strobe1),
    .pp_strobe1_drv (pp_strobe1_drv),
    .pp_strobe2     (pp_strobe2),
    .pp_sel         (pp_sel),
    .pp_sel_drv     (pp_sel_drv),
    .pp_data_oe     (pp_data_oe),
    .pp_rd_en       (pp_rd_en)
);

// File: tb/par_port_master_tb.sv
module par_port_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [3:0] cfg_wait = '0;
    logic       cfg_str1_en = 1'b0;
    logic       cfg_sel_en = 1'b0;
    logic       cfg_pull_en = 1'b0;
    logic       src_sel = 1'b0;
    logic       bus_tick = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [3:0] req_ep = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] pp_data_i = '0;
    logic       busy, rd_valid, pp_data_oe, pp_strobe1, pp_strobe1_drv;
    logic       pp_strobe2, pp_rd_en, pp_sel, pp_sel_drv, pp_pull_en;
    logic [7:0] rd_data, pp_data_o;

    int n_chk = 0;
    int n_bad = 0;
    int cur_mode, cur_w, cur_s1, cur_se, cur_pu;

    always #(CLK_PERIOD/2) clk = ~clk;

    par_port_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_wait(cfg_wait), .cfg_str1_en(cfg_str1_en), .cfg_sel_en(cfg_sel_en),
        .cfg_pull_en(cfg_pull_en), .src_sel(src_sel), .bus_tick(bus_tick),
        .req_valid(req_valid), .req_kind(req_kind), .req_ep(req_ep),
        .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe), .pp_data_i(pp_data_i),
        .pp_strobe1(pp_strobe1), .pp_strobe1_drv(pp_strobe1_drv),
        .pp_strobe2(pp_strobe2), .pp_rd_en(pp_rd_en), .pp_sel(pp_sel),
        .pp_sel_drv(pp_sel_drv), .pp_pull_en(pp_pull_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // 1 when strobe 1 is the routed strobe, 0 for strobe 2
    function automatic int routes_first(int mode, int kind, int ep);
        case (mode)
            0: return (kind == 0) ? 1 : 0;
            1: return (kind == 2) ? 0 : 1;
            default: return ep % 2;
        endcase
    endfunction

    task automatic set_cfg(input int mode, input int w, input int s1, input int se, input int pu);
        cfg_mode = 2'(mode); cfg_wait = 4'(w);
        cfg_str1_en = 1'(s1); cfg_sel_en = 1'(se); cfg_pull_en = 1'(pu);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_mode = mode; cur_w = w; cur_s1 = s1; cur_se = se; cur_pu = pu;
        chk("R2 pull flag after write", int'(pp_pull_en), pu);
        chk("R7 strobe1 drive flag", int'(pp_strobe1_drv), s1);
        chk("R7 select drive flag", int'(pp_sel_drv), se);
    endtask

    task automatic run_txn(input int kind, input int ep, input int bval, input int src, input int poke);
        int p, blen, c1, c2, cs, cr, co, dbad, early, first, exp_len, exp_hi;
        logic [7:0] rdpat;
        p = src ? 4 : 1;
        rdpat = 8'(bval) ^ 8'h5A ^ 8'(ep);
        pp_data_i = rdpat;
        src_sel = 1'(src);
        req_valid = 1'b1; req_kind = 2'(kind); req_ep = 4'(ep); req_wdata = 8'(bval);
        @(negedge clk);
        req_valid = 1'b0;
        blen = 0; c1 = 0; c2 = 0; cs = 0; cr = 0; co = 0; dbad = 0; early = 0;
        while (busy && blen < 400) begin
            blen++;
            c1 += int'(pp_strobe1); c2 += int'(pp_strobe2);
            cs += int'(pp_sel); cr += int'(pp_rd_en); co += int'(pp_data_oe);
            if (pp_data_oe && pp_data_o != 8'(bval)) dbad++;
            if (rd_valid) early++;
            req_valid = 1'b0; cfg_wr = 1'b0;
            if (poke != 0 && blen == 1) begin
                req_valid = 1'b1; req_kind = 2'd1; req_ep = 4'(ep ^ 1);
                cfg_wr = 1'b1; cfg_pull_en = 1'(cur_pu == 0);
                cfg_wait = 4'(cur_w ^ 1);
            end
            @(negedge clk);
        end
        req_valid = 1'b0; cfg_wr = 1'b0;
        exp_len = (2 + 2 * cur_w) * p;
        exp_hi  = (1 + cur_w) * p;
        first = routes_first(cur_mode, kind, ep);
        chk("R3 busy length", blen, exp_len);
        chk("R4 R5 R6 strobe1 high cycles", c1, (first == 1 && cur_s1 == 1) ? exp_hi : 0);
        chk("R4 R5 R6 strobe2 high cycles", c2, (first == 0) ? exp_hi : 0);
        chk("R8 select cycles", cs, cur_se ? exp_len : 0);
        chk("R9 read enable cycles", cr, (kind == 2) ? exp_len : 0);
        chk("R9 drive cycles", co, (kind == 2) ? 0 : exp_len);
        chk("R9 driven byte", dbad, 0);
        chk("R10 no early valid", early, 0);
        chk("R10 valid after read", int'(rd_valid), (kind == 2) ? 1 : 0);
        if (kind == 2) chk("R10 read byte", int'(rd_data), int'(rdpat));
        @(negedge clk);
        chk("R11 no extra transaction", int'(busy), 0);
        chk("R10 valid is a pulse", int'(rd_valid), 0);
        if (poke != 0) chk("R2 write ignored while busy", int'(pp_pull_en), cur_pu);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 strobes", int'(pp_strobe1) + int'(pp_strobe2), 0);
        chk("R1 rd_en and oe", int'(pp_rd_en) + int'(pp_data_oe), 0);
        chk("R1 select and flags", int'(pp_sel) + int'(pp_sel_drv) + int'(pp_strobe1_drv), 0);
        chk("R1 pull flag", int'(pp_pull_en), 0);
        cur_mode = 0; cur_w = 0; cur_s1 = 0; cur_se = 0; cur_pu = 0;
        run_txn(0, 3, 8'h11, 0, 0);

        for (int mode = 0; mode < 4; mode++) begin
            for (int wi = 0; wi < 4; wi++) begin
                for (int kind = 0; kind < 3; kind++) begin
                    for (int ep = 0; ep < 16; ep++) begin
                        set_cfg(mode, (wi == 3) ? 15 : wi, (ep >> 1) & 1, (ep >> 2) & 1, ep & 1);
                        run_txn(kind, ep, (ep * 37 + kind * 11 + mode) & 255, 0, 0);
                    end
                end
            end
        end

        for (int w = 0; w < 4; w++) begin
            for (int kind = 0; kind < 3; kind++) begin
                set_cfg(kind == 2 ? 3 : 1, w, 1, 1, 0);
                run_txn(kind, w + 4, 8'hA0 + w, 1, 0);
            end
        end

        for (int kind = 0; kind < 3; kind++) begin
            set_cfg(0, 2, 1, 1, kind & 1);
            run_txn(kind, 6, 8'h3C, kind & 1, 1);
        end

        req_valid = 1'b1; req_kind = 2'd3; req_ep = 4'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 reserved kind ignored", int'(busy), 0);
        @(negedge clk);
        chk("R11 reserved kind no strobe", int'(pp_strobe1) + int'(pp_strobe2), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule